// File: doc/BRIEF.md
# Reduced Feistel Round Engine

This block is a miniature sixteen-round Feistel cipher for 16-bit words. It follows the DES pattern at a reduced scale. A start pulse loads a plaintext word. The engine then runs one round per clock. For each round it presents the current round number on a key-index output, and receives the matching 12-bit subkey on an input in the same cycle. The subkeys therefore come from outside the block, typically from a small table that another block fills from a key schedule.

Each round's 16-bit result (new left half above new right half) is written out on a write strobe, together with the round index. This lets a storage array beside the engine keep all sixteen intermediate values for later viewing. When the last round completes, the engine pulses done for one cycle. The ciphertext output then holds its value until the next run finishes.

Top module: `mini_feistel_engine`

## Requirements
- R1: The plaintext is split with its upper byte (bits 15:8) as the left half and its lower byte (bits 7:0) as the right half. No permutation is applied before round 1.
- R2: The 8-bit right half is expanded to 12 bits. Take bit 1 as the MSB of the half (bit 7) and bit 8 as its LSB (bit 0). Reading the expanded word from its MSB down, the half's bit numbers are 1,2,3,4,5,4,5,6,7,8,8,1.
- R3: The expanded word is XORed with the 12-bit subkey. The result is cut into four 3-bit groups, with group 1 in the MSBs. In each group, the outer bits form the column, with the first (upper) bit as the column MSB. The middle bit selects the row.
- R4: The default S-box tables, listed as row 0 then row 1 for columns 0..3, are: box 1 {1,2,3,0},{0,2,1,3}; box 2 {2,0,3,1},{1,3,0,2}; box 3 {3,1,0,2},{2,0,1,3}; box 4 {0,3,2,1},{3,1,2,0}.
- R5: The round function result is the four 2-bit S-box outputs joined with box 1 in the MSBs. Each round sets the new left half to the old right half. It sets the new right half to the old left half XOR the round function result.
- R6: After round 16 the halves are swapped, so the ciphertext is {R16, L16}.
- R7: In the cycle after an accepted start, busy is high and the key index is 0. The index then rises by one every clock through 15, with busy high for exactly 16 cycles.
- R8: In each busy cycle, log_we_o is high, log_addr_o equals the key index, and log_data_o is that round's result {new left, new right}.
- R9: done_o is high for exactly one cycle, the cycle after round 16, with busy low. cipher_o takes its new value in that same cycle and holds it until the next completion.
- R10: A start while busy, and any change on the plaintext input during a run, has no effect on the round sequence or the results.
- R11: After reset, busy, done and log_we are low and cipher_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run when idle |
| plain_i | input | 16 | Plaintext, sampled on the accepted start |
| key_idx_o | output | 4 | Round number whose subkey is wanted |
| subkey_i | input | 12 | Subkey for key_idx_o, same cycle |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cipher_o | output | 16 | Ciphertext of the last finished run |
| log_we_o | output | 1 | Round result write strobe |
| log_addr_o | output | 4 | Round index of the written result |
| log_data_o | output | 16 | Round result {left, right} |

## Verification
A wrong S-box entry, expansion tap or group order corrupts the round-1 value on the log port in the very first busy cycle. The sweep over every right-half byte with several subkeys therefore exposes each table entry within one cycle of a start. A wrong half swap or key index shows up within one round on the log port and in the final ciphertext. Faults in the round counter or control logic show up as a mistimed done pulse, a busy window of the wrong length, or a ciphertext that changes on a start issued during a run.

// File: rtl/mini_feistel_engine.sv
module mini_feistel_engine #(
  parameter int          ROUNDS = 16,
  parameter logic [15:0] SBOX1  = 16'hD839,
  parameter logic [15:0] SBOX2  = 16'h8D72,
  parameter logic [15:0] SBOX3  = 16'hD287,
  parameter logic [15:0] SBOX4  = 16'h276C,
  localparam int         IW     = $clog2(ROUNDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [15:0]   plain_i,
  output logic [IW-1:0] key_idx_o,
  input  logic [11:0]   subkey_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [15:0]   cipher_o,
  output logic          log_we_o,
  output logic [IW-1:0] log_addr_o,
  output logic [15:0]   log_data_o
);

  localparam logic [IW-1:0] LAST = IW'(ROUNDS - 1);

  // table entry index is {row, column}, two bits per entry
  function automatic logic [1:0] sbox(input logic [15:0] tbl, input logic [2:0] grp);
    logic [2:0] a;
    a = {grp[1], grp[2], grp[0]};
    return tbl[{a, 1'b0} +: 2];
  endfunction

  logic [7:0]    lh, rh;
  logic [IW-1:0] rnd;
  logic [11:0]   mixed;
  logic [7:0]    fval, nr;

  assign mixed = {rh[7], rh[6], rh[5], rh[4], rh[3], rh[4],
                  rh[3], rh[2], rh[1], rh[0], rh[0], rh[7]} ^ subkey_i;
  assign fval  = {sbox(SBOX1, mixed[11:9]), sbox(SBOX2, mixed[8:6]),
                  sbox(SBOX3, mixed[5:3]),  sbox(SBOX4, mixed[2:0])};
  assign nr    = lh ^ fval;

  assign key_idx_o  = rnd;
  assign log_we_o   = busy_o;
  assign log_addr_o = rnd;
  assign log_data_o = {rh, nr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lh       <= '0;
      rh       <= '0;
      rnd      <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      cipher_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        lh  <= rh;
        rh  <= nr;
        rnd <= rnd + 1'b1;
        if (rnd == LAST) begin
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          cipher_o <= {nr, rh};
        end
      end else if (start_i) begin
        lh     <= plain_i[15:8];
        rh     <= plain_i[7:0];
        rnd    <= '0;
        busy_o <= 1'b1;
      end
    end
  end

  assert_start_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && key_idx_o == '0));

  assert_index_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && key_idx_o != LAST) |=> (busy_o && key_idx_o == $past(key_idx_o) + 1'b1));

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && key_idx_o == LAST) |=> (done_o && !busy_o));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_cipher_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(cipher_o));

  assert_left_from_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && key_idx_o != LAST) |=> log_data_o[15:8] == $past(log_data_o[7:0]));

endmodule

// File: tb/sim_mini_feistel_engine.sv
module sim_mini_feistel_engine;
  logic        clk = 0, rst_n = 0, start_i = 0;
  logic [15:0] plain_i = '0;
  logic [3:0]  key_idx_o, log_addr_o;
  logic [11:0] subkey_i;
  logic        busy_o, done_o, log_we_o;
  logic [15:0] cipher_o, log_data_o;

  logic [11:0] keys [16];
  int errors = 0, checks = 0;

  always #5 clk = ~clk;
  assign subkey_i = keys[key_idx_o];

  mini_feistel_engine u0 (.clk, .rst_n, .start_i, .plain_i, .key_idx_o, .subkey_i,
    .busy_o, .done_o, .cipher_o, .log_we_o, .log_addr_o, .log_data_o);

  int sbt [4][8] = '{'{1,2,3,0,0,2,1,3}, '{2,0,3,1,1,3,0,2},
                     '{3,1,0,2,2,0,1,3}, '{0,3,2,1,3,1,2,0}};
  int epos [12] = '{1,2,3,4,5,4,5,6,7,8,8,1};

  function automatic logic [7:0] fmodel(input logic [7:0] r, input logic [11:0] k);
    logic [11:0] x;
    logic [7:0] f;
    for (int i = 0; i < 12; i++) x[11-i] = r[8-epos[i]];
    x = x ^ k;
    for (int g = 0; g < 4; g++) begin
      int col, row;
      col = 2 * x[11-3*g] + x[9-3*g];
      row = x[10-3*g];
      f[7-2*g -: 2] = 2'(sbt[g][row*4+col]);
    end
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full run; noisy=1 raises start and alters plain_i mid-run (R10)
  task automatic run(input logic [15:0] pt, input bit noisy);
    logic [7:0] l, r, nl, nr;
    l = pt[15:8]; r = pt[7:0];
    plain_i = pt; start_i = 1;
    @(posedge clk); @(negedge clk);
    start_i = noisy;
    if (noisy) plain_i = ~pt;
    for (int i = 0; i < 16; i++) begin
      nl = r; nr = l ^ fmodel(r, keys[i]);
      chk(busy_o && key_idx_o == 4'(i), "R7 index", {busy_o, key_idx_o}, {1'b1, 4'(i)});
      chk(log_we_o && log_addr_o == 4'(i), "R8 log addr", {log_we_o, log_addr_o}, {1'b1, 4'(i)});
      chk(log_data_o == {nl, nr}, noisy ? "R10 R5 round" : "R5 R8 round", log_data_o, {nl, nr});
      l = nl; r = nr;
      @(negedge clk);
    end
    start_i = 0;
    chk(done_o && !busy_o, "R9 done", {done_o, busy_o}, 2'b10);
    chk(cipher_o == {r, l}, "R6 cipher", cipher_o, {r, l});
    @(negedge clk);
    chk(!done_o && cipher_o == {r, l}, "R9 hold", {done_o, cipher_o}, {1'b0, r, l});
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int i = 0; i < 16; i++) keys[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !log_we_o && cipher_o == 0, "R11 reset",
        {busy_o, done_o, log_we_o, cipher_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o, "R11 idle", busy_o, 0);
    // R2 R3 R4: every right-half byte against several subkeys, seen in round 1
    for (int kk = 0; kk < 6; kk++) begin
      for (int i = 0; i < 16; i++) keys[i] = 12'(kk * 12'h2AB + i * 12'h111);
      for (int b = 0; b < 256; b++) run({8'(b * 37 + kk), 8'(b)}, 0);
    end
    // R1: single-bit plaintexts expose the half split
    for (int i = 0; i < 16; i++) keys[i] = 12'(i * 12'h5A3);
    run(16'h8000, 0);
    run(16'h0001, 0);
    run(16'h0000, 0);
    // R10: start and plaintext changes during a run are ignored
    seed = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      seed = seed * 1664525 + 1013904223;
      for (int i = 0; i < 16; i++) keys[i] = 12'(seed >> i);
      run(seed[31:16], n[0]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule